// File: doc/BRIEF.md
# Masked Address Window Decoder

This block holds the address-window programming of a bus bridge and decides, for any 64-bit address, which of six windows it falls into. The windows are a configuration window, a message window, three outbound memory windows and a register window. Each window has a 64-bit base, loaded one 32-bit half at a time, and a mask. Bit 0 of a mask's low word turns the window on. The window size is derived from the rest of the mask.

Software reaches the 23 registers through a simple write port and a combinational read port. The word offsets keep a fixed order, because firmware depends on it. A probe address is compared against every enabled window. The block returns a one-hot vector that names the lowest-numbered matching window, or all zeros when no window matches. Forwarding and translating transactions is left to other logic.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads 0 and no probe address hits any window.
- R2: Word offsets are fixed. Configuration window: base high 0, base low 1, mask 2. Message window: base high 3, base low 4, mask 5. Outbound window n (n = 0..2): base high 6+4n, base low 7+4n, mask high 8+4n, mask low 9+4n. Register window: base high 18, base low 19, mask 20. Spare register 21, control register 22. Every register reads back the last value written to it. Offsets 23 to 31 read as 0, and writes to them change nothing.
- R3: A write to a high half sets bits 63:32 and leaves bits 31:0 alone. A write to a low half sets bits 31:0 and leaves bits 63:32 alone.
- R4: A window can hit only while bit 0 of its mask's low word is 1.
- R5: For the configuration, message and register windows the size is the 32-bit two's complement of the mask with bit 0 cleared. A window whose size works out to zero never hits.
- R6: The configuration window size is limited to CFG_SIZE_MAX (default 0x1000_0000). A mask of 0xE0000001 therefore gives 0x1000_0000 bytes.
- R7: A register-window mask equal to 0x00007001 gives a 4096-byte window. Any other mask follows R5.
- R8: An outbound window size is the 64-bit two's complement of its 64-bit mask with bit 0 cleared.
- R9: An enabled window hits when base <= address < base + size, with the upper bound computed without wrap-around. A window that ends exactly at 2^64 therefore covers the top address.
- R10: When several windows match, only the lowest-numbered one is flagged (bit 0 configuration, bit 1 message, bits 2 to 4 outbound 0 to 2, bit 5 register). win_hit never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ofs | input | OFS_W | Register word offset, used for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_ofs (combinational) |
| probe_addr | input | 64 | Address to classify |
| win_hit | output | 6 | One-hot hit vector, bit n = window n |

## Verification
The assertions assume that the write strobe and offset are driven cleanly on the clock and that probe_addr is stable around the sampling edge. They do not depend on the masks being contiguous, so arbitrary mask values are legal stimulus. The random stimulus uses masks of the form "all ones above a power of two, plus the enable bit", with bases drawn from a narrow range so that windows overlap often. Probes land inside a chosen window, on its last byte, one past its end and one below its base. Directed cases cover the clamp, the 4096-byte special code, a zero-sized window and a window that reaches the top of the address space.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int          OFS_W          = 5,
  parameter logic [63:0] CFG_SIZE_MAX   = 64'h0000_0000_1000_0000,
  parameter logic [31:0] REG_FIXED_CODE = 32'h0000_7001,
  parameter logic [63:0] REG_FIXED_SIZE = 64'd4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFS_W-1:0] cfg_ofs,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [63:0]      probe_addr,
  output logic [5:0]       win_hit
);
  localparam int NWIN = 6;
  localparam int NOB  = 3;
  localparam logic [OFS_W-1:0] O_CFG  = OFS_W'(0);
  localparam logic [OFS_W-1:0] O_MSG  = OFS_W'(3);
  localparam logic [OFS_W-1:0] O_OB   = OFS_W'(6);
  localparam logic [OFS_W-1:0] O_REG  = OFS_W'(18);
  localparam logic [OFS_W-1:0] O_SPR  = OFS_W'(21);
  localparam logic [OFS_W-1:0] O_CTL  = OFS_W'(22);

  logic [63:0] base_q  [NWIN];
  logic [63:0] omask_q [NOB];
  logic [31:0] cmask_q, mmask_q, rmask_q, spr_q, ctl_q;

  function automatic logic [63:0] neg32(input logic [31:0] m);
    logic [31:0] t;
    t = ~(m & 32'hFFFF_FFFE) + 32'd1;
    return {32'd0, t};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) base_q[i] <= '0;
      for (int i = 0; i < NOB; i++) omask_q[i] <= '0;
      cmask_q <= '0;
      mmask_q <= '0;
      rmask_q <= '0;
      spr_q   <= '0;
      ctl_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_ofs)
        O_CFG:         base_q[0][63:32] <= cfg_wdata;
        O_CFG + 1'b1:  base_q[0][31:0]  <= cfg_wdata;
        O_CFG + 2'd2:  cmask_q          <= cfg_wdata;
        O_MSG:         base_q[1][63:32] <= cfg_wdata;
        O_MSG + 1'b1:  base_q[1][31:0]  <= cfg_wdata;
        O_MSG + 2'd2:  mmask_q          <= cfg_wdata;
        O_REG:         base_q[5][63:32] <= cfg_wdata;
        O_REG + 1'b1:  base_q[5][31:0]  <= cfg_wdata;
        O_REG + 2'd2:  rmask_q          <= cfg_wdata;
        O_SPR:         spr_q            <= cfg_wdata;
        O_CTL:         ctl_q            <= cfg_wdata;
        default: ;
      endcase
      for (int i = 0; i < NOB; i++) begin
        if (cfg_ofs == O_OB + OFS_W'(4*i))     base_q[2+i][63:32] <= cfg_wdata;
        if (cfg_ofs == O_OB + OFS_W'(4*i + 1)) base_q[2+i][31:0]  <= cfg_wdata;
        if (cfg_ofs == O_OB + OFS_W'(4*i + 2)) omask_q[i][63:32]  <= cfg_wdata;
        if (cfg_ofs == O_OB + OFS_W'(4*i + 3)) omask_q[i][31:0]   <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_ofs)
      O_CFG:        cfg_rdata = base_q[0][63:32];
      O_CFG + 1'b1: cfg_rdata = base_q[0][31:0];
      O_CFG + 2'd2: cfg_rdata = cmask_q;
      O_MSG:        cfg_rdata = base_q[1][63:32];
      O_MSG + 1'b1: cfg_rdata = base_q[1][31:0];
      O_MSG + 2'd2: cfg_rdata = mmask_q;
      O_REG:        cfg_rdata = base_q[5][63:32];
      O_REG + 1'b1: cfg_rdata = base_q[5][31:0];
      O_REG + 2'd2: cfg_rdata = rmask_q;
      O_SPR:        cfg_rdata = spr_q;
      O_CTL:        cfg_rdata = ctl_q;
      default: ;
    endcase
    for (int i = 0; i < NOB; i++) begin
      if (cfg_ofs == O_OB + OFS_W'(4*i))     cfg_rdata = base_q[2+i][63:32];
      if (cfg_ofs == O_OB + OFS_W'(4*i + 1)) cfg_rdata = base_q[2+i][31:0];
      if (cfg_ofs == O_OB + OFS_W'(4*i + 2)) cfg_rdata = omask_q[i][63:32];
      if (cfg_ofs == O_OB + OFS_W'(4*i + 3)) cfg_rdata = omask_q[i][31:0];
    end
  end

  logic [63:0]     sz [NWIN];
  logic [NWIN-1:0] en;
  logic [NWIN-1:0] raw;

  always_comb begin
    en    = {rmask_q[0], omask_q[2][0], omask_q[1][0], omask_q[0][0], mmask_q[0], cmask_q[0]};
    sz[0] = neg32(cmask_q);
    if (sz[0] > CFG_SIZE_MAX) sz[0] = CFG_SIZE_MAX;
    sz[1] = neg32(mmask_q);
    for (int i = 0; i < NOB; i++) sz[2+i] = ~(omask_q[i] & ~64'h1) + 64'd1;
    sz[5] = (rmask_q == REG_FIXED_CODE) ? REG_FIXED_SIZE : neg32(rmask_q);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign raw[w] = en[w] && (sz[w] != '0) && (probe_addr >= base_q[w]) &&
                    ({1'b0, probe_addr} < ({1'b0, base_q[w]} + {1'b0, sz[w]}));
  end

  assign win_hit = raw & (~raw + 1'b1);

  // R10
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win_hit));
  // R3
  low_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_ofs == O_CFG + 1'b1 |=> $stable(base_q[0][63:32]));
  // R3
  high_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_ofs == O_REG |=> $stable(base_q[5][31:0]));
  // R4
  cfg_off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmask_q[0] |-> !win_hit[0]);
  // R4
  ob_off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !omask_q[1][0] |-> !win_hit[3]);
  // R6
  cfg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit[0] |-> (probe_addr - base_q[0]) < CFG_SIZE_MAX);
endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] probe_addr = '0;
  logic [5:0]  win_hit;

  int checks = 0;
  int errors = 0;
  logic [31:0] img [23];

  always #2 clk = ~clk;

  addr_window_decoder i_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .probe_addr(probe_addr), .win_hit(win_hit));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ofs = 5'(ofs); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ofs < 23) img[ofs] = d;
  endtask

  task automatic rd(input int ofs, output logic [31:0] d);
    @(negedge clk);
    cfg_ofs = 5'(ofs);
    #1 d = cfg_rdata;
  endtask

  task automatic probe(input logic [63:0] a, output logic [5:0] h);
    @(negedge clk);
    probe_addr = a;
    #1 h = win_hit;
  endtask

  function automatic int boff(input int w);
    case (w)
      0: return 0;  1: return 3;  2: return 6;
      3: return 10; 4: return 14; default: return 18;
    endcase
  endfunction

  function automatic logic [63:0] mbase(input int w);
    return {img[boff(w)], img[boff(w)+1]};
  endfunction

  function automatic logic [63:0] n32(input logic [31:0] m);
    logic [31:0] t;
    t = 32'd0 - (m & ~32'd1);
    return {32'd0, t};
  endfunction

  function automatic logic [63:0] msize(input int w);
    logic [63:0] s, m;
    if (w == 0) begin
      s = n32(img[2]);
      return (s > 64'h1000_0000) ? 64'h1000_0000 : s;
    end
    if (w == 1) return n32(img[5]);
    if (w == 5) return (img[20] == 32'h7001) ? 64'd4096 : n32(img[20]);
    m = {img[boff(w)+2], img[boff(w)+3]};
    return 64'd0 - (m & ~64'd1);
  endfunction

  function automatic logic men(input int w);
    if (w == 0) return img[2][0];
    if (w == 1) return img[5][0];
    if (w == 5) return img[20][0];
    return img[boff(w)+3][0];
  endfunction

  function automatic logic [5:0] exp_hit(input logic [63:0] a);
    for (int w = 0; w < 6; w++) begin
      logic [63:0] b, s;
      b = mbase(w); s = msize(w);
      if (men(w) && s != 0 && a >= b && ({1'b0, a} < {1'b0, b} + {1'b0, s}))
        return 6'(1 << w);
    end
    return 6'd0;
  endfunction

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  h;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 23; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 24; i++) begin
      rd(i, d); chk(d, 0, "R1 reset read");
    end
    probe(64'h0, h); chk(h, 0, "R1 no hit after reset");

    // R2 readback in offset order
    for (int i = 0; i < 23; i++) wr(i, 32'hA500_0000 + i);
    for (int i = 0; i < 23; i++) begin
      rd(i, d); chk(d, 32'hA500_0000 + i, "R2 readback");
    end
    wr(25, 32'hFFFF_FFFF);
    rd(25, d); chk(d, 0, "R2 unmapped read zero");
    for (int i = 0; i < 23; i++) begin
      rd(i, d); chk(d, img[i], "R2 unmapped write ignored");
    end
    for (int i = 0; i < 23; i++) wr(i, 0);

    // R3 halves
    wr(0, 32'h1); wr(1, 32'h2000_0000); wr(0, 32'h3);
    rd(1, d); chk(d, 32'h2000_0000, "R3 low kept");
    wr(1, 32'h4); rd(0, d); chk(d, 32'h3, "R3 high kept");

    // R6 clamp
    wr(0, 32'h1); wr(1, 32'h0); wr(2, 32'hE000_0001);
    probe(64'h1_0FFF_FFFF, h); chk(h, 6'b000001, "R6 inside clamp");
    probe(64'h1_1000_0000, h); chk(h, 6'b000000, "R6 past clamp");
    probe(64'h0_FFFF_FFFF, h); chk(h, 6'b000000, "R9 below base");
    wr(2, 32'hE000_0000);
    probe(64'h1_0000_0000, h); chk(h, 6'b000000, "R4 cfg disabled");

    // R7 special code
    wr(18, 0); wr(19, 32'h8000_0000); wr(20, 32'h7001);
    probe(64'h8000_0FFF, h); chk(h, 6'b100000, "R7 last byte");
    probe(64'h8000_1000, h); chk(h, 6'b000000, "R7 past 4096");
    wr(20, 32'hFFFF_0001);
    probe(64'h8000_FFFF, h); chk(h, 6'b100000, "R5 negated mask");

    // R10 priority, R4 enable, R5 zero size
    wr(3, 0); wr(4, 32'h8000_0000); wr(5, 32'hFFFF_F001);
    probe(64'h8000_0010, h); chk(h, 6'b000010, "R10 lower index wins");
    wr(5, 32'hFFFF_F000);
    probe(64'h8000_0010, h); chk(h, 6'b100000, "R4 msg disabled");
    wr(5, 32'h1);
    probe(64'h8000_0000, h); chk(h, 6'b100000, "R5 zero size never hits");
    wr(5, 0);

    // R8 outbound 64-bit mask
    wr(6, 32'h10); wr(7, 0); wr(8, 32'hFFFF_FFF0); wr(9, 32'h1);
    probe(64'h1F_FFFF_FFFF, h); chk(h, 6'b000100, "R8 inside 64-bit size");
    probe(64'h20_0000_0000, h); chk(h, 6'b000000, "R8 past 64-bit size");

    // R9 window reaching the top of the space
    wr(14, 32'hFFFF_FFFF); wr(15, 32'hFFFF_F000); wr(16, 32'hFFFF_FFFF); wr(17, 32'hFFFF_F001);
    probe(64'hFFFF_FFFF_FFFF_FFFF, h); chk(h, 6'b010000, "R9 top address");
    probe(64'hFFFF_FFFF_FFFF_EFFF, h); chk(h, 6'b000000, "R9 below top window");

    // random windows and probes (R4 R5 R8 R9 R10)
    for (int r = 0; r < 30; r++) begin
      for (int w = 0; w < 6; w++) begin
        logic en;
        logic [31:0] hi, lo;
        en = ($urandom % 4) != 0;
        hi = $urandom % 2;
        lo = $urandom & 32'hFFF0_0000;
        wr(boff(w), hi); wr(boff(w) + 1, lo);
        if (w >= 2 && w <= 4) begin
          logic [63:0] m;
          m = ~((64'd1 << (12 + $urandom % 29)) - 1) | {63'd0, en};
          wr(boff(w) + 2, m[63:32]); wr(boff(w) + 3, m[31:0]);
        end else begin
          logic [31:0] m;
          if (w == 5 && ($urandom % 4) == 0) m = 32'h7000 | {31'd0, en};
          else m = ~((32'd1 << (12 + $urandom % 16)) - 1) | {31'd0, en};
          wr(boff(w) + 2, m);
        end
      end
      for (int p = 0; p < 20; p++) begin
        int w;
        logic [63:0] b, s, a;
        w = $urandom % 6;
        b = mbase(w); s = msize(w);
        if (s == 0) s = 64'd4096;
        case ($urandom % 4)
          0: a = b + ({$urandom, $urandom} % s);
          1: a = b + s - 1;
          2: a = b + s;
          default: a = b - 1;
        endcase
        probe(a, h); chk(h, exp_hit(a), "R9 R10 random probe");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule